// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a processor core and decides which of five interrupt sources the core should take next. One source is a non-maskable trap. Three are restart requests at high, middle and low priority, each with its own mask bit. The fifth is a general request whose handler address comes from the requesting device. A global enable flip-flop gates every source except the trap. The core changes the enable with enable and disable command strobes, and changes the masks with a mask-write command.

The core raises `boundary_i` at each instruction boundary. On that clock edge the controller looks at every eligible source and takes the one with the highest priority. In the next cycle it drives `take_o` for one cycle. For the trap and the restart sources it also drives a fixed 16-bit handler address. For the general request it raises `ext_vec_o` and pulses the active-low acknowledge, so that the device can place an instruction on the bus. A status word shows the masks, the enable flip-flop and the pending request lines.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset `take_o` and `ext_vec_o` are 0, `inta_n_o` is 1, all three masks are set and the global enable is clear. With the enable clear, the general request cannot be taken.
- R2: When several sources are eligible at one boundary, the controller takes the highest-priority source. The order from highest to lowest is trap, high restart, middle restart, low restart, general request.
- R3: The handler addresses on `vec_o` are 0x0024 for the trap, 0x003C for the high restart, 0x0034 for the middle restart and 0x002C for the low restart.
- R4: The trap is taken whatever the global enable and the masks hold.
- R5: `cmd_di_i` clears the global enable and `cmd_ei_i` sets it. While the enable is clear, no source except the trap is taken.
- R6: In the mask-write data, bit 3 means "apply". When it is set, bits 2, 1 and 0 become the masks of the high, middle and low restart sources (1 = masked). When bit 3 is clear, the masks are not changed.
- R7: A rising edge on `irq_hi_i` sets a pending latch. The latch holds after the input falls and is cleared when the source is taken, or by a mask write with bit 4 set (whether or not bit 3 is set).
- R8: The middle restart, the low restart and the general request are level-sensitive. A request that falls before the boundary is not taken.
- R9: When the general request is taken, `take_o` and `ext_vec_o` are 1, `vec_o` is 0, and `inta_n_o` is low for exactly that one cycle.
- R10: Taking any maskable source clears the global enable. Taking the trap leaves the enable unchanged.
- R11: The trap is taken only after a rising edge on `nmi_i`, and only while the input is still high. A trap that was taken is not taken again until the input falls and rises once more.
- R12: A source is taken only on an edge where `boundary_i` is high. `take_o` is high exactly in the cycle after that edge.
- R13: The bits of `status_o` are: [2:0] the masks {high, middle, low}; [3] the global enable; [6:4] the pending state {high latch, middle input, low input}; [7] the general request input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Non-maskable trap request |
| irq_hi_i | input | 1 | High-priority restart request, edge-sensed |
| irq_mid_i | input | 1 | Middle-priority restart request, level-sensed |
| irq_lo_i | input | 1 | Low-priority restart request, level-sensed |
| ext_req_i | input | 1 | General request; the handler address comes from the device |
| boundary_i | input | 1 | Instruction boundary from the core |
| cmd_ei_i | input | 1 | Set the global enable |
| cmd_di_i | input | 1 | Clear the global enable |
| cmd_msk_wr_i | input | 1 | Mask-write strobe |
| cmd_msk_data_i | input | 5 | Mask-write data: [2:0] masks, [3] apply, [4] clear high latch |
| take_o | output | 1 | One-cycle pulse: take an interrupt |
| ext_vec_o | output | 1 | The taken source is the general request |
| vec_o | output | VEC_W | Handler address of the taken source |
| inta_n_o | output | 1 | Acknowledge for the general request, active low |
| status_o | output | 8 | Masks, enable and pending lines |

## Verification
Every decision comes from the single clock edge where `boundary_i` is sampled high. The bench therefore drives `boundary_i` for one cycle and checks `take_o`, `vec_o`, `ext_vec_o` and `inta_n_o` at the next falling edge. It checks `inta_n_o` again one cycle later to confirm that it has returned high. A request edge or a command takes effect at the first rising edge after it is driven, so the bench checks the status word at the falling edge that follows. Tests of the edge-sensed inputs always leave at least one edge between the input change and the boundary.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int NSRC       = 5;
   localparam int SRC_IDX_W  = $clog2(NSRC);
   localparam int MSK_N      = 3;
   localparam int CMD_W      = 5;
   localparam int APPLY_BIT  = 3;
   localparam int CLR_HI_BIT = 4;
   localparam int STAT_W     = 8;

   typedef enum logic [SRC_IDX_W-1:0] {
      SRC_NMI = 3'd0,
      SRC_HI  = 3'd1,
      SRC_MID = 3'd2,
      SRC_LO  = 3'd3,
      SRC_EXT = 3'd4
   } src_e;

   // Handler address by priority slot: trap at 0x24, restarts spaced by 8 upward
   function automatic logic [31:0] vec_of(input logic [SRC_IDX_W-1:0] p);
      if (p == SRC_NMI) return 32'h24;
      return 32'h24 + 32'(8 * (4 - int'(p)));
   endfunction
endpackage

// File: rtl/vic_edge_latch.sv
module vic_edge_latch #(
   parameter bit HOLD_HIGH = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_i,
   input  logic clr_i,
   output logic pend_o
);
   logic prev_q, pend_q, pend_d, rise;

   assign rise = in_i & ~prev_q;

   generate
      if (HOLD_HIGH) begin : g_hold
         // request lives only while the line stays high
         assign pend_d = in_i & (rise | (pend_q & ~clr_i));
      end else begin : g_latch
         // request survives the line falling; a fresh edge beats a clear
         assign pend_d = rise | (pend_q & ~clr_i);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= in_i;
         pend_q <= pend_d;
      end
   end

   assign pend_o = pend_q;

   p_pend_from_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(in_i));
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
   parameter int N     = 5,
   localparam int IW   = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_i,
   output logic [N-1:0]  grant_o,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);
   generate
      if (N < 2) begin : g_bad_n
         $error("vic_prio_pick needs at least two requesters");
      end
   endgenerate

   // index 0 is the highest priority
   always_comb begin
      grant_o = '0;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            grant_o    = '0;
            grant_o[i] = 1'b1;
            idx_o      = IW'(i);
         end
      end
   end

   assign any_o = |req_i;

   p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));
   p_grant_in_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o & ~req_i) == '0);
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
   import vic_pkg::*;
#(
   parameter int VEC_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 nmi_i,
   input  logic                 irq_hi_i,
   input  logic                 irq_mid_i,
   input  logic                 irq_lo_i,
   input  logic                 ext_req_i,
   input  logic                 boundary_i,
   input  logic                 cmd_ei_i,
   input  logic                 cmd_di_i,
   input  logic                 cmd_msk_wr_i,
   input  logic [CMD_W-1:0]     cmd_msk_data_i,
   output logic                 take_o,
   output logic                 ext_vec_o,
   output logic [VEC_W-1:0]     vec_o,
   output logic                 inta_n_o,
   output logic [STAT_W-1:0]    status_o
);
   generate
      if (VEC_W < 8 || VEC_W > 32) begin : g_bad_vec
         $error("VEC_W must lie between 8 and 32");
      end
   endgenerate

   localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(32'h24);

   logic [MSK_N-1:0]     mask_q;
   logic                 ien_q;
   logic                 nmi_pend, hi_pend;
   logic [NSRC-1:0]      elig, grant;
   logic [SRC_IDX_W-1:0] win_idx;
   logic                 any_elig, accept, clr_hi;

   vic_edge_latch #(.HOLD_HIGH(1'b1)) u_nmi_lat (
      .clk(clk), .rst_n(rst_n), .in_i(nmi_i),
      .clr_i(accept & grant[SRC_NMI]), .pend_o(nmi_pend));

   assign clr_hi = (accept & grant[SRC_HI]) | (cmd_msk_wr_i & cmd_msk_data_i[CLR_HI_BIT]);

   vic_edge_latch #(.HOLD_HIGH(1'b0)) u_hi_lat (
      .clk(clk), .rst_n(rst_n), .in_i(irq_hi_i),
      .clr_i(clr_hi), .pend_o(hi_pend));

   assign elig[SRC_NMI] = nmi_pend;
   assign elig[SRC_HI]  = hi_pend   & ~mask_q[2] & ien_q;
   assign elig[SRC_MID] = irq_mid_i & ~mask_q[1] & ien_q;
   assign elig[SRC_LO]  = irq_lo_i  & ~mask_q[0] & ien_q;
   assign elig[SRC_EXT] = ext_req_i & ien_q;

   vic_prio_pick #(.N(NSRC)) u_pick (
      .clk(clk), .rst_n(rst_n), .req_i(elig),
      .grant_o(grant), .idx_o(win_idx), .any_o(any_elig));

   assign accept = boundary_i & any_elig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q  <= 1'b0;
         mask_q <= '1;
      end else begin
         if (accept && !grant[SRC_NMI]) ien_q <= 1'b0;
         else if (cmd_di_i)             ien_q <= 1'b0;
         else if (cmd_ei_i)             ien_q <= 1'b1;
         if (cmd_msk_wr_i && cmd_msk_data_i[APPLY_BIT])
            mask_q <= cmd_msk_data_i[MSK_N-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o    <= 1'b0;
         ext_vec_o <= 1'b0;
         inta_n_o  <= 1'b1;
         vec_o     <= '0;
      end else begin
         take_o    <= accept;
         ext_vec_o <= accept & grant[SRC_EXT];
         inta_n_o  <= ~(accept & grant[SRC_EXT]);
         vec_o     <= (accept && !grant[SRC_EXT]) ? VEC_W'(vec_of(win_idx)) : '0;
      end
   end

   assign status_o = {ext_req_i, hi_pend, irq_mid_i, irq_lo_i, ien_q, mask_q};

   p_take_at_boundary_r12: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> $past(boundary_i));
   p_ack_only_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !inta_n_o |-> (take_o && ext_vec_o && vec_o == '0));
   p_ien_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && (ext_vec_o || vec_o != NMI_VEC)) |-> !ien_q);
   p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_msk_wr_i |=> $stable(mask_q));
endmodule

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic nmi = 0, hi = 0, mid = 0, lo = 0, ext = 0, bnd = 0;
   logic ei = 0, di = 0, mwr = 0;
   logic [4:0] mdat = '0;
   logic take, extv, inta_n;
   logic [15:0] vec;
   logic [7:0] stat;
   int n_vec = 0, n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   prio_vec_intc dut (
      .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .irq_hi_i(hi), .irq_mid_i(mid),
      .irq_lo_i(lo), .ext_req_i(ext), .boundary_i(bnd), .cmd_ei_i(ei),
      .cmd_di_i(di), .cmd_msk_wr_i(mwr), .cmd_msk_data_i(mdat),
      .take_o(take), .ext_vec_o(extv), .vec_o(vec), .inta_n_o(inta_n),
      .status_o(stat));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic pulse_ei(); ei = 1; tick(); ei = 0; endtask
   task automatic pulse_di(); di = 1; tick(); di = 0; endtask
   task automatic msk(input logic [4:0] d); mwr = 1; mdat = d; tick(); mwr = 0; mdat = '0; endtask

   // drive a boundary for one cycle, then check the registered result
   task automatic fire(input string tag, input logic exp_take, input logic exp_ext,
                       input logic [15:0] exp_vec);
      bnd = 1; tick(); bnd = 0;
      chk({tag, " take"}, 32'(take), 32'(exp_take));
      chk({tag, " ext"},  32'(extv), 32'(exp_ext));
      chk({tag, " vec"},  32'(vec),  32'(exp_vec));
      chk({tag, " inta_n"}, 32'(inta_n), 32'(!(exp_take && exp_ext)));
      tick();
   endtask

   task automatic t_reset();
      chk("R1 take", 32'(take), 0);
      chk("R1 inta_n", 32'(inta_n), 1);
      chk("R1/R13 status", 32'(stat), 32'h07);
      mid = 1; lo = 1; ext = 1; tick();
      chk("R13 pending bits", 32'(stat), 32'hB7);
      fire("R1/R5 disabled", 0, 0, 16'h0);
      msk(5'h08);
      chk("R6 apply masks", 32'(stat[2:0]), 0);
      fire("R5 enable clear", 0, 0, 16'h0);
      mid = 0; lo = 0; ext = 0; tick();
   endtask

   task automatic t_priority();
      mid = 1; lo = 1; ext = 1; hi = 1; tick();
      pulse_ei();
      fire("R2/R3 high", 1, 0, 16'h003C);
      chk("R10 ien cleared", 32'(stat[3]), 0);
      chk("R7 latch cleared by service", 32'(stat[6]), 0);
      pulse_ei();
      fire("R2/R3 mid", 1, 0, 16'h0034);
      pulse_ei(); mid = 0;
      fire("R2/R3 low", 1, 0, 16'h002C);
      pulse_ei(); lo = 0;
      bnd = 1; tick(); bnd = 0;
      chk("R9 take", 32'(take), 1);
      chk("R9 ext", 32'(extv), 1);
      chk("R9 vec", 32'(vec), 0);
      chk("R9 inta low", 32'(inta_n), 0);
      tick();
      chk("R9 inta one cycle", 32'(inta_n), 1);
      ext = 0; hi = 0; tick();
   endtask

   task automatic t_boundary_only();
      pulse_ei(); ext = 1;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R12 no take without boundary", 32'(take), 0);
      end
      ext = 0; pulse_di();
   endtask

   task automatic t_trap();
      msk(5'h0F);
      pulse_ei();
      nmi = 1; tick();
      fire("R4 trap", 1, 0, 16'h0024);
      chk("R10 trap keeps ien", 32'(stat[3]), 1);
      pulse_di();
      fire("R11 no retake held high", 0, 0, 16'h0);
      nmi = 0; tick(); nmi = 1; tick(); nmi = 0; tick();
      fire("R11 fell before boundary", 0, 0, 16'h0);
      nmi = 1; tick();
      fire("R4/R11 new edge disabled", 1, 0, 16'h0024);
      nmi = 0; tick();
   endtask

   task automatic t_hi_latch();
      msk(5'h08);
      hi = 1; tick(); hi = 0; tick();
      chk("R7 latch holds", 32'(stat[6]), 1);
      msk(5'h10);
      chk("R7 clear by command", 32'(stat[6]), 0);
      chk("R6 masks kept", 32'(stat[2:0]), 0);
      msk(5'h07);
      chk("R6 no apply no change", 32'(stat[2:0]), 0);
   endtask

   task automatic t_mask_sel();
      msk(5'h0A);
      chk("R6 mask mid", 32'(stat[2:0]), 32'h2);
      pulse_ei(); mid = 1; lo = 1; tick();
      fire("R6 mid masked", 1, 0, 16'h002C);
      mid = 0; lo = 0; msk(5'h08);
      pulse_ei(); mid = 1; tick(); mid = 0;
      fire("R8 level gone", 0, 0, 16'h0);
      chk("R8 ien kept", 32'(stat[3]), 1);
      pulse_di(); lo = 1; tick();
      fire("R5 disabled", 0, 0, 16'h0);
      lo = 0; tick();
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1; tick();
      t_reset();
      t_priority();
      t_boundary_only();
      t_trap();
      t_hi_latch();
      t_mask_sel();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule